// File: doc/BRIEF.md
# Sticky Floating-Point Exception Flag Register

This block keeps six sticky exception flags that live in a field of a floating-point unit's control register. The arithmetic datapath pulses one strobe per exception class in any cycle where that exception arises. If the matching enable bit is clear, the exception is masked and recorded in its flag. Once a flag is set, it stays set across any number of later operations. If the enable bit is set, the flag is left alone and the block instead raises a single-cycle trap request for the trap logic.

Software reads the flags through the control-register read port. Software can only lower flags: each bit of a write is taken on its own, so a 0 clears that flag and a 1 keeps it as it is. In a cycle where a masked exception and a clearing write hit the same flag, the exception wins, so no exception is ever lost. The flag field comes out of reset with an undefined value. Software is expected to clear it before it relies on the flags.

Top module: `fpu_sticky_flags`

## Requirements
- R1: The flags occupy control-register bits 11 down to 6, in this order: bit 11 denormal input, bit 10 inexact, bit 9 underflow, bit 8 overflow, bit 7 divide-by-zero, bit 6 invalid. Strobe and enable index 5 maps to bit 11 and index 0 maps to bit 6.
- R2: A strobe whose enable bit is 0 sets its flag. The set flag is visible on the read port from the next cycle onward.
- R3: A write takes each flag bit of its data separately. A 0 clears that flag and a 1 leaves it unchanged, so a write never sets a flag.
- R4: A set flag stays set until a write clears it, whatever later strobes or enable values arrive.
- R5: When a masked strobe and a clearing write address the same flag in the same cycle, the flag ends up set.
- R6: A strobe whose enable bit is 1 leaves its flag unchanged. It drives trap_req high for exactly the following cycle.
- R7: Read-data bits outside 11:6 are always 0. Write-data bits outside 11:6 have no effect.
- R8: The read port shows the flag values held at the start of the cycle. A change made in a cycle appears on the read port in the next cycle.
- R9: Any number of strobes can be active in one cycle, and each is handled for its own bit only.
- R10: trap_req is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (trap output only) |
| exc_evt | input | 6 | Per-class exception strobes, index 5 = denormal ... index 0 = invalid |
| exc_en | input | 6 | Per-class trap enables, same indexing |
| reg_we | input | 1 | Control-register write strobe |
| reg_wdata | input | 32 | Control-register write data |
| reg_rdata | output | 32 | Control-register read data (flag field only) |
| trap_req | output | 1 | One-cycle trap request for an enabled exception |

## Verification
The assertions assume that the flag register has a defined value after reset. They do not assume it is clear, and they rely only on how the register changes between cycles. They also assume that the strobes, enables, write strobe and write data are stable at the clock edge. The bench changes its inputs on the falling edge only. Before each vector it forces a known flag state by writing all zeros and then pulsing masked strobes. Every expected value therefore comes from a known starting pattern and never from the undefined reset contents.

// File: rtl/fpu_sticky_flags.sv
module fpu_sticky_flags #(
  parameter int NFLAG    = 6,
  parameter int FLAG_LSB = 6,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  exc_evt,
  input  logic [NFLAG-1:0]  exc_en,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              trap_req
);

  localparam int FLAG_MSB = FLAG_LSB + NFLAG - 1;

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] masked_set;
  logic [NFLAG-1:0] clr_mask;
  logic [NFLAG-1:0] flags_nxt;

  assign masked_set = exc_evt & ~exc_en;
  assign clr_mask   = reg_we ? ~reg_wdata[FLAG_MSB:FLAG_LSB] : '0;
  assign flags_nxt  = (flags & ~clr_mask) | masked_set;

  // Flag field has no defined reset value by design.
  always_ff @(posedge clk)
    flags <= flags_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trap_req <= 1'b0;
    else        trap_req <= |(exc_evt & exc_en);

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FLAG_MSB:FLAG_LSB] = flags;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |masked_set |=> ((flags & $past(masked_set)) == $past(masked_set)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((flags & $past(flags)) == $past(flags)));

  // R3/R6: a flag may only rise from a masked strobe
  p_rise_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(masked_set)) == '0));

  p_trap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(|(exc_evt & exc_en)));

  p_outside_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~({{(DATA_W-NFLAG){1'b0}}, {NFLAG{1'b1}}} << FLAG_LSB)) == '0);

  p_reset_trap_r10: assert property (@(posedge clk)
    !rst_n |-> !trap_req);

endmodule

// File: tb/fpu_sticky_flags_tb.sv
`timescale 1ns/1ps
module fpu_sticky_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  exc_evt = '0;
  logic [5:0]  exc_en = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trap_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpu_sticky_flags u_dut (
    .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .exc_en(exc_en),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trap_req(trap_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] e, input logic [5:0] en, input logic we, input logic [31:0] wd);
    exc_evt = e; exc_en = en; reg_we = we; reg_wdata = wd;
    @(negedge clk);
    exc_evt = '0; exc_en = '0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic load(input logic [5:0] v);
    drive('0, '0, 1'b1, 32'h0);
    drive(v, '0, 1'b0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] e32;
    repeat (3) @(negedge clk);
    check(trap_req === 1'b0, "R10 trap in reset", {31'b0, trap_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: bit placement
    load(6'b100000);
    check(reg_rdata === 32'h800, "R1 denormal at bit11", reg_rdata, 32'h800);
    load(6'b000001);
    check(reg_rdata === 32'h040, "R1 invalid at bit6", reg_rdata, 32'h040);
    load(6'b000100);
    check(reg_rdata === 32'h100, "R1 overflow at bit8", reg_rdata, 32'h100);

    // R7: outside write bits ignored
    load('0);
    drive('0, '0, 1'b1, 32'hFFFF_FFFF);
    check(reg_rdata === 32'h0, "R7 write of ones sets nothing", reg_rdata, 0);

    for (int we = 0; we < 2; we++) begin
      for (int init = 0; init < 64; init++) begin
        for (int ev = 0; ev < 64; ev++) begin
          logic [5:0] en, wf, expf;
          logic [31:0] wd;
          en = 6'((init * 7 + ev * 3 + we * 11) & 63);
          wf = 6'((init ^ (ev * 5)) & 63);
          wd = 32'hFFFF_F03F | ({26'b0, wf} << 6);
          load(6'(init));
          exc_evt = 6'(ev); exc_en = en; reg_we = we[0]; reg_wdata = wd;
          #1;
          check(reg_rdata === {20'b0, 6'(init), 6'b0}, "R8 read shows old value",
                reg_rdata, {20'b0, 6'(init), 6'b0});
          @(negedge clk);
          exc_evt = '0; exc_en = '0; reg_we = 1'b0; reg_wdata = '0;
          expf = (6'(init) & (we[0] ? wf : 6'h3F)) | (6'(ev) & ~en);
          e32 = {20'b0, expf, 6'b0};
          check(reg_rdata === e32, "R2/R3/R5/R6/R9 update", reg_rdata, e32);
          check(trap_req === |(6'(ev) & en), "R6 trap pulse",
                {31'b0, trap_req}, {31'b0, |(6'(ev) & en)});
          drive(6'(ev), 6'h3F, 1'b0, 32'h0);
          check(reg_rdata === e32, "R4 hold under enabled strobes", reg_rdata, e32);
          @(negedge clk);
          check(trap_req === 1'b0, "R6 trap lasts one cycle", {31'b0, trap_req}, 0);
        end
      end
    end

    // R5 directed: set and clear same bit
    load(6'b001000);
    drive(6'b001000, '0, 1'b1, 32'h0);
    check(reg_rdata === 32'h200, "R5 set wins over clear", reg_rdata, 32'h200);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule